// File: doc/BRIEF.md
# Cycle Peak Detector with Integral Phase Compensator

This block closes the outer current loop of a resonant inverter controller. It receives 8-bit samples of the output current, each flagged by a valid bit, and one strobe for each switching cycle. Within each cycle it keeps the largest valid sample. On the strobe it publishes that maximum as the cycle peak and begins a new search.

One clock after the peak is published, the block compares it against a reference level and updates an integrating compensator. The difference (reference minus peak) is clamped to a signed 4-bit error. The compensator state is an 11-bit accumulator whose two lowest bits are fractional, so adding the error directly gives an integral gain of one quarter. The 9-bit phase command sent to the inner phase loop is the accumulator with its fraction bits dropped.

During start-up an external sequencer drives the phase. While `track_en` is high, the accumulator is loaded with that phase on every clock. When tracking ends, integration continues from the same value, so the command does not jump.

Top module: `peak_integ_loop`

## Requirements
- R1: While reset is held, `peak_out` and `phase_cmd` are 0 and `cmd_update` is low.
- R2: `peak_out` takes the largest value of `smp_data` among the clocks, since the previous strobe, in which `smp_valid` was high. A clock with `smp_valid` low does not count, whatever `smp_data` holds. If no valid sample arrived in that window, the peak is 0.
- R3: A clock with `cyc_strobe` high starts a new search. A sample that is valid in that same clock belongs to the new cycle. Without such a sample, the search starts from 0.
- R4: `peak_out` shows the new peak after the clock edge on which the strobe is sampled. On the edge after that, the accumulator takes its new value and `cmd_update` is high for exactly that one clock.
- R5: The error is `ref_level` minus the latched peak, clamped to the range -8..+7 as a two's complement 4-bit value.
- R6: On each update, the error is added to the 11-bit accumulator, in units of a quarter phase code. `phase_cmd` equals the accumulator divided by 4, rounded down (bits 10:2).
- R7: The accumulator saturates at 0 and at 2047 and never wraps.
- R8: On every clock where `track_en` is high, the accumulator is set to `track_phase`×4. A strobe during tracking integrates nothing, and `phase_cmd` equals `track_phase`. Integration continues from that value once `track_en` falls.
- R9: Except on an update or while tracking, `phase_cmd` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Marks `smp_data` as a current sample |
| smp_data | input | 8 | Output current sample |
| cyc_strobe | input | 1 | One pulse per switching cycle; latches the peak |
| ref_level | input | 8 | Reference peak current |
| track_en | input | 1 | Loads the accumulator from `track_phase` |
| track_phase | input | 9 | Phase to follow during start-up |
| peak_out | output | 8 | Peak of the last completed cycle |
| phase_cmd | output | 9 | Phase command to the inner loop |
| cmd_update | output | 1 | High in the clock a new command appears |

## Verification
The hardest states to reach are the two accumulator rails. With a gain of one quarter and an error of at most 8, walking up from reset would take hundreds of cycles. The bench therefore uses the tracking input to place the accumulator just inside each limit, releases it, and then drives a cycle with the largest possible error to push it against the rail. The same sequence shows that integration continues from the tracked value and that a strobe during tracking has no effect.

// File: rtl/peak_integ_pkg.sv
package peak_integ_pkg;
  localparam int SMP_W  = 8;
  localparam int ERR_W  = 4;
  localparam int PH_W   = 9;
  localparam int FRAC_W = 2;

  // clamp a raw difference into a signed field of ew bits
  function automatic int clamp_err(int diff, int ew);
    int lo, hi;
    lo = -(1 << (ew - 1));
    hi = (1 << (ew - 1)) - 1;
    if (diff < lo) return lo;
    if (diff > hi) return hi;
    return diff;
  endfunction

  // integrate one step, saturating to an unsigned field of aw bits
  function automatic int integ_step(int acc, int err, int aw);
    int s, top;
    s   = acc + err;
    top = (1 << aw) - 1;
    if (s < 0)   return 0;
    if (s > top) return top;
    return s;
  endfunction
endpackage

// File: rtl/cycle_peak_tracker.sv
module cycle_peak_tracker
  import peak_integ_pkg::*;
#(
  parameter int W = SMP_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_data,
  input  logic         cyc_strobe,
  output logic [W-1:0] peak_q,
  output logic         latch_evt
);
  logic [W-1:0] run_max;
  logic         bigger;

  assign bigger = smp_valid && (smp_data > run_max);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_max   <= '0;
      peak_q    <= '0;
      latch_evt <= 1'b0;
    end else begin
      latch_evt <= cyc_strobe;
      if (cyc_strobe) begin
        peak_q  <= run_max;
        run_max <= smp_valid ? smp_data : '0;
      end else if (bigger) begin
        run_max <= smp_data;
      end
    end
  end

  // R3: a strobe without a sample restarts the search from zero
  a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_strobe && !smp_valid |=> run_max == '0);
  // R2: the running maximum never decreases inside a cycle
  a_r2_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_strobe |=> run_max >= $past(run_max));
  // R4: the strobe publishes the running maximum
  a_r4_publish: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_strobe |=> peak_q == $past(run_max));
endmodule

// File: rtl/integ_compensator.sv
module integ_compensator
  import peak_integ_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int EW = ERR_W,
  parameter int PW = PH_W,
  parameter int FW = FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch_evt,
  input  logic [SW-1:0] peak_in,
  input  logic [SW-1:0] ref_level,
  input  logic          track_en,
  input  logic [PW-1:0] track_phase,
  output logic [PW-1:0] phase_cmd,
  output logic          upd_evt
);
  localparam int AW = PW + FW;

  logic [AW-1:0]        acc;
  logic [AW-1:0]        acc_nxt;
  logic signed [EW-1:0] err_q;
  int                   diff_i;

  assign diff_i  = int'(ref_level) - int'(peak_in);
  assign err_q   = EW'(clamp_err(diff_i, EW));
  assign acc_nxt = AW'(integ_step(int'(acc), int'(err_q), AW));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      upd_evt <= 1'b0;
    end else begin
      upd_evt <= latch_evt;
      if (track_en)       acc <= {track_phase, {FW{1'b0}}};
      else if (latch_evt) acc <= acc_nxt;
    end
  end

  assign phase_cmd = acc[AW-1:FW];

  // R8: tracking loads the accumulator
  a_r8_track_follow: assert property (@(posedge clk) disable iff (!rst_n)
    track_en |=> acc == {$past(track_phase), {FW{1'b0}}});
  // R9: no change outside updates and tracking
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !track_en && !latch_evt |=> $stable(acc));
  // R5/R7: one update moves the state by at most the clamped error
  a_r7_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    latch_evt && !track_en |=>
      (int'(acc) - int'($past(acc)) <= (1 << (EW - 1)) - 1) &&
      (int'(acc) - int'($past(acc)) >= -(1 << (EW - 1))));
endmodule

// File: rtl/peak_integ_loop.sv
module peak_integ_loop
  import peak_integ_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int EW = ERR_W,
  parameter int PW = PH_W,
  parameter int FW = FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [SW-1:0] smp_data,
  input  logic          cyc_strobe,
  input  logic [SW-1:0] ref_level,
  input  logic          track_en,
  input  logic [PW-1:0] track_phase,
  output logic [SW-1:0] peak_out,
  output logic [PW-1:0] phase_cmd,
  output logic          cmd_update
);
  logic latch_evt;

  cycle_peak_tracker #(.W(SW)) u_peak (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_valid  (smp_valid),
    .smp_data   (smp_data),
    .cyc_strobe (cyc_strobe),
    .peak_q     (peak_out),
    .latch_evt  (latch_evt)
  );

  integ_compensator #(.SW(SW), .EW(EW), .PW(PW), .FW(FW)) u_comp (
    .clk         (clk),
    .rst_n       (rst_n),
    .latch_evt   (latch_evt),
    .peak_in     (peak_out),
    .ref_level   (ref_level),
    .track_en    (track_en),
    .track_phase (track_phase),
    .phase_cmd   (phase_cmd),
    .upd_evt     (cmd_update)
  );

  // R4: command update follows the strobe by two edges
  a_r4_update_timing: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_strobe |=> ##1 cmd_update);
  // R4: the update pulse is never longer than one clock for an isolated strobe
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_update && !latch_evt |=> !cmd_update);
endmodule

// File: tb/peak_integ_loop_test.sv
module peak_integ_loop_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       smp_valid, cyc_strobe, track_en, cmd_update;
  logic [7:0] smp_data, ref_level, peak_out;
  logic [8:0] track_phase, phase_cmd;

  always #5 clk = ~clk;

  peak_integ_loop uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .cyc_strobe(cyc_strobe), .ref_level(ref_level), .track_en(track_en),
    .track_phase(track_phase), .peak_out(peak_out), .phase_cmd(phase_cmd),
    .cmd_update(cmd_update)
  );

  int n_run = 0, n_fail = 0;
  int q_peak[$], q_ph[$];
  int m_max = 0, m_acc = 0, m_track = 0;
  bit tracking = 0, done = 0;

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic sample(int v, bit vld = 1'b1);
    smp_valid = vld; smp_data = 8'(v);
    if (vld && v > m_max) m_max = v;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic strobe(int refv, int s = -1);
    int pk, e;
    ref_level = 8'(refv);
    cyc_strobe = 1'b1;
    if (s >= 0) begin smp_valid = 1'b1; smp_data = 8'(s); end
    pk = m_max;
    m_max = (s >= 0) ? s : 0;
    e = refv - pk;
    if (e > 7) e = 7;
    if (e < -8) e = -8;
    if (tracking) m_acc = m_track * 4;
    else begin
      m_acc = m_acc + e;
      if (m_acc < 0) m_acc = 0;
      if (m_acc > 2047) m_acc = 2047;
    end
    q_peak.push_back(pk);
    q_ph.push_back(m_acc / 4);
    @(negedge clk);
    cyc_strobe = 1'b0; smp_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic track_on(int v);
    track_en = 1'b1; track_phase = 9'(v);
    tracking = 1; m_track = v; m_acc = v * 4;
    @(negedge clk);
  endtask

  task automatic track_off();
    track_en = 1'b0; tracking = 0;
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && cmd_update) begin
      if (q_ph.size() == 0) chk("R4 unexpected update", 1, 0);
      else begin
        chk("R2 peak", int'(peak_out), q_peak.pop_front());
        chk("R6 phase", int'(phase_cmd), q_ph.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int hold;
    rst_n = 1'b0; smp_valid = 0; smp_data = 0; cyc_strobe = 0;
    ref_level = 0; track_en = 0; track_phase = 0;
    repeat (3) @(negedge clk);
    chk("R1 peak", int'(peak_out), 0);
    chk("R1 phase", int'(phase_cmd), 0);
    chk("R1 update", int'(cmd_update), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: max of valid samples; invalid large sample ignored
    sample(10); sample(50); sample(200, 1'b0); sample(30);
    strobe(52);
    chk("R2 ignored invalid", int'(peak_out), 50);
    sample(5); sample(90);
    strobe(100);
    sample(255, 1'b0);
    strobe(20);                       // R3 no samples -> peak 0
    chk("R3 empty cycle", int'(peak_out), 0);

    // R3: sample in the strobe clock opens the next cycle
    strobe(40, 40);
    strobe(40);
    chk("R3 strobe-cycle sample", int'(peak_out), 40);

    // R5/R8: track to 100, then clamped errors
    track_on(100);
    chk("R8 track", int'(phase_cmd), 100);
    strobe(255);                      // during tracking: no integration
    chk("R8 strobe ignored", int'(phase_cmd), 100);
    track_off();
    strobe(255);                      // +7 -> 407
    chk("R5 positive clamp", int'(phase_cmd), 101);
    sample(200);
    strobe(0);                        // -8 -> 399
    chk("R5 negative clamp", int'(phase_cmd), 99);

    // R7: upper rail
    track_on(511); track_off();
    strobe(255); strobe(255);
    chk("R7 upper rail", int'(phase_cmd), 511);
    // R7: lower rail
    track_on(1); track_off();
    sample(255);
    strobe(0);
    chk("R7 lower rail", int'(phase_cmd), 0);

    // R9: command holds between updates despite samples
    hold = int'(phase_cmd);
    sample(77); sample(12); sample(200); sample(0, 1'b0);
    chk("R9 hold", int'(phase_cmd), hold);

    repeat (4) @(negedge clk);
    chk("R4 queue drained", q_ph.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule